// File: doc/BRIEF.md
# Fixed-Priority Shared Memory Bus Arbiter

This block decides which of four masters drives a shared memory bus: a DRAM refresh engine, an external hold requester, a DMA engine and the CPU. Their priority is wired in and cannot be changed. Each master presents a request line. The block also watches the current owner's progress signals and returns a one-hot grant vector. Ownership moves only at a safe point. For the CPU, the safe point is the end of its bus cycle. For the DMA engine, it is the last beat of the 8-bit or 16-bit transfer unit in progress. For the hold requester, it is the fall of its request. For refresh, it is its done pulse.

When refresh or hold takes the bus away from the DMA engine in the middle of a burst, the engine gets the bus back once the intruder leaves. A one-cycle resume pulse tells it to continue from its next address instead of starting its transfer again. The block counts the bus beats that make up each DMA unit. A narrow unit and a wide unit each take a number of beats that is set by a parameter. A wide unit may need several beats on a narrow bus.

The reset input is asynchronous and active-low. Its release is synchronised to the clock inside the block, so internal reset ends two clock edges after `rst_n` rises.

Top module: `sysbus_arbiter`

## Requirements
- R1: While reset is active, and until the first ownership change after it, the CPU holds the bus: `grant` is 4'b0001, and `hold_ack` and `dma_resume` are low.
- R2: Exactly one bit of `grant` is high in every cycle. The bit positions are fixed: bit 0 is the CPU, bit 1 the DMA engine, bit 2 the hold requester and bit 3 refresh.
- R3: At an ownership boundary the next owner is chosen by fixed priority: refresh first, then hold, then DMA, then the CPU. The CPU is granted when nothing else requests.
- R4: The CPU keeps the bus until `cpu_cycle_end` is sampled high on a rising edge. Any change of grant appears in the cycle after that edge. `cpu_cycle_end` must be held high while the CPU is idle.
- R5: The DMA engine keeps the bus through a whole transfer unit, even while refresh or hold is requesting. A unit ends on the `dma_beat_done` edge that completes NARROW_BEATS beats when `dma_wide` is low, or WIDE_BEATS beats when `dma_wide` is high. `dma_wide` must stay steady within a unit.
- R6: When a unit ends with `dma_req` still high and neither refresh nor hold requesting, the DMA engine keeps the bus for its next unit.
- R7: When `dma_req` is low at a unit boundary (no beats counted in the current unit), the DMA engine releases the bus to the highest remaining requester, or to the CPU if there is none.
- R8: The hold requester owns the bus for as long as `hold_req` stays high. `hold_ack` is high exactly while the hold grant is active and `hold_req` is high, and it falls in the same cycle that `hold_req` falls.
- R9: Refresh owns the bus from the moment it is granted until `rfsh_done` is sampled high.
- R10: A DMA request raised during refresh or hold is not granted until that owner leaves. It is then granted, provided nothing of higher priority is requesting.
- R11: `dma_resume` is high for exactly one cycle: the first cycle of a DMA grant that follows a refresh or hold preemption, with `dma_req` held high throughout. It stays low on a fresh DMA grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cpu_cycle_end | input | 1 | CPU bus cycle ends this edge, or the CPU is idle |
| dma_req | input | 1 | DMA engine wants the bus |
| dma_wide | input | 1 | Current DMA unit is 16-bit (1) or 8-bit (0) |
| dma_beat_done | input | 1 | One DMA bus beat completes this edge |
| hold_req | input | 1 | External hold request, level |
| rfsh_req | input | 1 | DRAM refresh request |
| rfsh_done | input | 1 | Refresh operation finished this edge |
| grant | output | 4 | One-hot owner: [0] CPU, [1] DMA, [2] hold, [3] refresh |
| hold_ack | output | 1 | Hold acknowledge |
| dma_resume | output | 1 | One-cycle pulse: DMA regained the bus after preemption |

## Verification
The bench builds the arbiter with NARROW_BEATS=1 and WIDE_BEATS=3, rather than the default of two wide beats. With three beats, a hold request raised during the middle beat of a wide unit must wait through a beat that is neither the first nor the last. This exposes a beat counter that stops early or runs over. Keeping a single narrow beat makes the refresh-preempts-narrow-unit case land on the very first beat, so the same run covers both extremes of unit length.

// File: rtl/sba_pkg.sv
package sba_pkg;

  // Owner encoding doubles as the grant bit index.
  typedef enum logic [1:0] {
    OWN_CPU  = 2'd0,
    OWN_DMA  = 2'd1,
    OWN_HOLD = 2'd2,
    OWN_RFSH = 2'd3
  } owner_e;

  localparam int unsigned NUM_MASTERS = 4;
  localparam int unsigned OWNER_W     = 2;

endpackage

// File: rtl/sba_rst_sync.sv
module sba_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift ones in once the asynchronous reset lets go.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sba_prio_pick.sv
module sba_prio_pick
  import sba_pkg::*;
(
  input  logic   rfsh_req,
  input  logic   hold_req,
  input  logic   dma_req,
  output owner_e pick
);

  // Fixed ranking, highest first; CPU is the fallback owner.
  always_comb begin
    if (rfsh_req) begin
      pick = OWN_RFSH;
    end else if (hold_req) begin
      pick = OWN_HOLD;
    end else if (dma_req) begin
      pick = OWN_DMA;
    end else begin
      pick = OWN_CPU;
    end
  end

endmodule

// File: rtl/sba_dma_unit.sv
module sba_dma_unit #(
  parameter int unsigned NARROW_BEATS = 1,
  parameter int unsigned WIDE_BEATS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic beat_done,
  input  logic wide,
  output logic unit_done,
  output logic unit_idle
);

  localparam int unsigned MAX_BEATS = (WIDE_BEATS > NARROW_BEATS) ? WIDE_BEATS : NARROW_BEATS;
  localparam int unsigned CNT_W     = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_BEATS - 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_BEATS - 1);

  logic [CNT_W-1:0] beat_cnt_q;
  logic [CNT_W-1:0] beat_cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic             cnt_en;

  always_comb begin
    last_idx  = wide ? WIDE_LAST : NARROW_LAST;
    unit_done = active && beat_done && (beat_cnt_q == last_idx);
    unit_idle = (beat_cnt_q == '0);
    cnt_en    = (!active) || beat_done;
    if (!active || unit_done) begin
      beat_cnt_d = '0;
    end else begin
      beat_cnt_d = beat_cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt_q <= '0;
    end else if (cnt_en) begin
      beat_cnt_q <= beat_cnt_d;
    end
  end

  // R5: the counter never passes the last beat index of the widest unit.
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt_q <= WIDE_LAST || beat_cnt_q <= NARROW_LAST);

  // R5: a beat that does not finish the unit advances the count by one.
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && beat_done && !unit_done) |=> (beat_cnt_q == $past(beat_cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/sba_owner_ctrl.sv
module sba_owner_ctrl
  import sba_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cpu_cycle_end,
  input  logic   dma_req,
  input  logic   hold_req,
  input  logic   rfsh_req,
  input  logic   rfsh_done,
  input  logic   unit_done,
  input  logic   unit_idle,
  input  owner_e pick,
  output owner_e owner_q,
  output logic   resume_q
);

  owner_e owner_d;
  logic   at_bnd;
  logic   pend_q;
  logic   pend_d;
  logic   resume_d;
  logic   dma_enter;
  logic   dma_leave;

  // Safe point for each kind of owner.
  always_comb begin
    unique case (owner_q)
      OWN_CPU:  at_bnd = cpu_cycle_end;
      OWN_DMA:  at_bnd = unit_done || (!dma_req && unit_idle);
      OWN_HOLD: at_bnd = !hold_req;
      OWN_RFSH: at_bnd = rfsh_done;
      default:  at_bnd = 1'b1;
    endcase
    owner_d = at_bnd ? pick : owner_q;
  end

  // Preemption bookkeeping for the resume pulse.
  always_comb begin
    dma_enter = (owner_d == OWN_DMA) && (owner_q != OWN_DMA);
    dma_leave = (owner_q == OWN_DMA) && (owner_d != OWN_DMA);
    resume_d  = dma_enter && pend_q && dma_req;
    if (dma_leave && dma_req) begin
      pend_d = 1'b1;
    end else if (dma_enter || !dma_req) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_CPU;
      pend_q   <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_q   <= pend_d;
      resume_q <= resume_d;
    end
  end

  // R4: the CPU is not displaced mid-cycle.
  a_r4_cpu_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_CPU && !cpu_cycle_end) |=> (owner_q == OWN_CPU));

  // R5: an unfinished DMA unit keeps the bus.
  a_r5_dma_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_DMA && dma_req && !unit_done) |=> (owner_q == OWN_DMA));

  // R8: hold ownership persists while requested.
  a_r8_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_HOLD && hold_req) |=> (owner_q == OWN_HOLD));

  // R9: refresh ownership persists until done.
  a_r9_rfsh_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_RFSH && !rfsh_done) |=> (owner_q == OWN_RFSH));

  // R3: refresh wins at the end of a CPU cycle.
  a_r3_rfsh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_CPU && cpu_cycle_end && rfsh_req) |=> (owner_q == OWN_RFSH));

  // R11: the resume pulse only appears with a DMA grant and lasts one cycle.
  a_r11_resume_dma: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> (owner_q == OWN_DMA && $past(owner_q) != OWN_DMA));

endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
  import sba_pkg::*;
#(
  parameter int unsigned NARROW_BEATS = 1,
  parameter int unsigned WIDE_BEATS   = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_cycle_end,
  input  logic                   dma_req,
  input  logic                   dma_wide,
  input  logic                   dma_beat_done,
  input  logic                   hold_req,
  input  logic                   rfsh_req,
  input  logic                   rfsh_done,
  output logic [NUM_MASTERS-1:0] grant,
  output logic                   hold_ack,
  output logic                   dma_resume
);

  logic   rst_n_sync;
  owner_e pick;
  owner_e owner_q;
  logic   unit_done;
  logic   unit_idle;
  logic   resume_q;
  logic   dma_active;

  sba_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sba_prio_pick u_pick (
    .rfsh_req (rfsh_req),
    .hold_req (hold_req),
    .dma_req  (dma_req),
    .pick     (pick)
  );

  assign dma_active = (owner_q == OWN_DMA);

  sba_dma_unit #(
    .NARROW_BEATS (NARROW_BEATS),
    .WIDE_BEATS   (WIDE_BEATS)
  ) u_dma_unit (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .active    (dma_active),
    .beat_done (dma_beat_done),
    .wide      (dma_wide),
    .unit_done (unit_done),
    .unit_idle (unit_idle)
  );

  sba_owner_ctrl u_owner (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .cpu_cycle_end (cpu_cycle_end),
    .dma_req       (dma_req),
    .hold_req      (hold_req),
    .rfsh_req      (rfsh_req),
    .rfsh_done     (rfsh_done),
    .unit_done     (unit_done),
    .unit_idle     (unit_idle),
    .pick          (pick),
    .owner_q       (owner_q),
    .resume_q      (resume_q)
  );

  // One grant line per owner code.
  for (genvar gi = 0; gi < NUM_MASTERS; gi++) begin : g_grant
    assign grant[gi] = (owner_q == owner_e'(gi));
  end

  assign hold_ack   = grant[OWN_HOLD] && hold_req;
  assign dma_resume = resume_q;

  // R2: one owner at all times.
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $countones(grant) == 1);

  // R8: acknowledge never outlives the request.
  a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n_sync)
    hold_ack |-> hold_req);

endmodule

// File: tb/sysbus_arbiter_tb.sv
module sysbus_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_cycle_end, dma_req, dma_wide, dma_beat_done;
  logic       hold_req, rfsh_req, rfsh_done;
  logic [3:0] grant;
  logic       hold_ack, dma_resume;
  int         errors = 0;
  int         checks = 0;

  localparam logic [3:0] G_CPU  = 4'b0001;
  localparam logic [3:0] G_DMA  = 4'b0010;
  localparam logic [3:0] G_HOLD = 4'b0100;
  localparam logic [3:0] G_RFSH = 4'b1000;

  always #5 clk = ~clk;

  sysbus_arbiter #(.NARROW_BEATS(1), .WIDE_BEATS(3)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_cycle_end (cpu_cycle_end),
    .dma_req       (dma_req),
    .dma_wide      (dma_wide),
    .dma_beat_done (dma_beat_done),
    .hold_req      (hold_req),
    .rfsh_req      (rfsh_req),
    .rfsh_done     (rfsh_done),
    .grant         (grant),
    .hold_ack      (hold_ack),
    .dma_resume    (dma_resume)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] eg, logic eack, logic eres);
    checks++;
    if (grant !== eg || hold_ack !== eack || dma_resume !== eres || $countones(grant) != 1) begin
      errors++;
      $display("FAIL %s: grant=%b ack=%b resume=%b expected grant=%b ack=%b resume=%b",
               req, grant, hold_ack, dma_resume, eg, eack, eres);
    end
  endtask

  task automatic idle_inputs();
    cpu_cycle_end = 1'b1; dma_req = 1'b0; dma_wide = 1'b0; dma_beat_done = 1'b0;
    hold_req = 1'b0; rfsh_req = 1'b0; rfsh_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    tick();
    chk("R1 in reset", G_CPU, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    chk("R1 after release", G_CPU, 1'b0, 1'b0);
  endtask

  task automatic t_wide_unit_hold();
    cpu_cycle_end = 1'b0; dma_req = 1'b1;
    tick();
    chk("R4 cpu mid cycle", G_CPU, 1'b0, 1'b0);
    tick();
    chk("R4 cpu still mid cycle", G_CPU, 1'b0, 1'b0);
    cpu_cycle_end = 1'b1;
    tick();
    chk("R11 fresh dma grant", G_DMA, 1'b0, 1'b0);
    dma_wide = 1'b1; dma_beat_done = 1'b1;
    tick();
    hold_req = 1'b1;
    tick();
    chk("R5 wide unit beat 2 of 3", G_DMA, 1'b0, 1'b0);
    tick();
    dma_beat_done = 1'b0;
    chk("R5 hold after wide unit", G_HOLD, 1'b1, 1'b0);
    tick(); tick();
    chk("R8 hold persists", G_HOLD, 1'b1, 1'b0);
    hold_req = 1'b0;
    #1;
    chk("R8 ack falls with request", G_HOLD, 1'b0, 1'b0);
    tick();
    chk("R11 resume after hold", G_DMA, 1'b0, 1'b1);
    tick();
    chk("R11 resume one cycle", G_DMA, 1'b0, 1'b0);
  endtask

  task automatic t_narrow_unit_rfsh();
    dma_wide = 1'b0; rfsh_req = 1'b1; dma_beat_done = 1'b1;
    tick();
    dma_beat_done = 1'b0;
    chk("R5 refresh after narrow unit", G_RFSH, 1'b0, 1'b0);
    tick(); tick();
    chk("R9 refresh persists", G_RFSH, 1'b0, 1'b0);
    rfsh_req = 1'b0; rfsh_done = 1'b1;
    tick();
    rfsh_done = 1'b0;
    chk("R11 resume after refresh", G_DMA, 1'b0, 1'b1);
  endtask

  task automatic t_burst_and_release();
    dma_beat_done = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    chk("R6 burst keeps dma", G_DMA, 1'b0, 1'b0);
    dma_beat_done = 1'b0; dma_req = 1'b0;
    tick();
    chk("R7 dma release to cpu", G_CPU, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    cpu_cycle_end = 1'b0; rfsh_req = 1'b1; hold_req = 1'b1; dma_req = 1'b1;
    tick();
    chk("R4 cpu keeps bus under requests", G_CPU, 1'b0, 1'b0);
    cpu_cycle_end = 1'b1;
    tick();
    chk("R3 refresh first", G_RFSH, 1'b0, 1'b0);
    rfsh_req = 1'b0; rfsh_done = 1'b1;
    tick();
    rfsh_done = 1'b0;
    chk("R3 hold over dma", G_HOLD, 1'b1, 1'b0);
    hold_req = 1'b0;
    tick();
    chk("R3 dma over cpu, R11 no resume", G_DMA, 1'b0, 1'b0);
    dma_req = 1'b0;
    tick();
    tick();
    chk("R3 cpu default", G_CPU, 1'b0, 1'b0);
  endtask

  task automatic t_dma_waits_hold();
    hold_req = 1'b1;
    tick();
    chk("R8 hold granted", G_HOLD, 1'b1, 1'b0);
    dma_req = 1'b1;
    tick(); tick();
    chk("R10 dma waits during hold", G_HOLD, 1'b1, 1'b0);
    hold_req = 1'b0;
    tick();
    chk("R10 dma after hold", G_DMA, 1'b0, 1'b0);
    dma_req = 1'b0;
    tick();
    chk("R7 back to cpu", G_CPU, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_wide_unit_hold();
    t_narrow_unit_rfsh();
    t_burst_and_release();
    t_priority();
    t_dma_waits_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule